// File: doc/BRIEF.md
# Serial Peripheral Slave with Edge-Accurate Completion

This block is the receiving end of a four-wire synchronous serial link. An external master drives a serial clock, a data line and an active-low select; the block shifts the master's bits into a receive word and, in the same frame, shifts out a word that local logic preloaded into a holding register. Clock idle level, clock phase, frame length and bit order are fixed by parameters at build time.

All three serial inputs are brought into the system clock domain through two flip-flops, and clock edges are found by comparing the synchronized clock with its previous value. For this to work, the serial clock must run at no more than a quarter of the system clock. Each completed frame raises a one-cycle completion pulse, presents the received word and advances a wrapping frame counter. Completion is reported on the final serial clock edge of the frame, which is the second edge of the last bit. If the select is released before that edge, the frame is dropped without any report. Data-out is driven, and its enable raised, only while the select is active.

Top module: `spi_slv_core`

## Requirements
- R1: The select, clock and data inputs each pass through two synchronizing flops. An assertion of the select driven before system clock edge k raises `miso_oe_o` after edge k+2, and `miso_oe_o` falls the same way when the select is released.
- R2: With CLK_PHASE=0, once the select is seen the first bit of the transmit word appears on `miso_o` before any serial clock edge.
- R3: With CLK_PHASE=0, data-in is sampled on the leading serial clock edges (odd-numbered) and the next transmit bit is presented on the trailing edges (even-numbered).
- R4: With CLK_PHASE=1, `miso_o` stays 0 after select until the first leading edge, which presents the first bit. Later leading edges shift the output and trailing edges sample data-in.
- R5: `done_o` is a one-cycle pulse issued only on the last (2*FRAME_BITS-th) serial clock edge of a frame. In the same cycle `rx_count_o` increases by exactly 1 and `rx_data_o` shows the received word. At no other time does `rx_count_o` change.
- R6: LSB_FIRST=0 sends and receives the most significant bit first. LSB_FIRST=1 sends and receives bit 0 first.
- R7: CLK_IDLE gives the idle level of the serial clock (0 = low, 1 = high). A leading edge moves the clock away from that level and a trailing edge returns it.
- R8: Releasing the select before a frame's last edge aborts the frame. No `done_o` pulse is produced, `rx_count_o` is unchanged, and the next frame starts counting from bit 0.
- R9: A frame that starts with no word loaded since the previous frame took its word transmits all zeros.
- R10: While the select is inactive, `miso_oe_o` and `miso_o` are 0, and serial clock edges have no effect.
- R11: With the select held active, frames follow each other directly, and each new frame transmits the word loaded during the frame before.
- R12: Out of reset, `miso_o`, `miso_oe_o`, `done_o`, `rx_data_o` and `rx_count_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ssel_ni | input | 1 | Slave select, active low |
| tx_data_i | input | FRAME_BITS | Word to transmit in a coming frame |
| tx_load_i | input | 1 | Writes `tx_data_i` into the holding register |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| rx_data_o | output | FRAME_BITS | Last completed received word |
| done_o | output | 1 | One-cycle frame completion pulse |
| rx_count_o | output | CNT_W | Count of completed frames, wrapping |

## Verification
The hardest case to reach from the ports is a frame that follows another with the select still held. This case matters most with phase 0, where the next word has to be taken out of the holding register at the completion edge itself, before the master's next leading edge arrives. To reach it, the stimulus writes the following word in the middle of the running frame and goes straight on to a second frame. An aborted partial frame is then followed by a frame with no load at all. Two instances are built: one uses low idle, phase 0 and MSB-first, the other high idle, phase 1 and LSB-first. Both are compared every cycle against a behavioural model.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    // Raw or synchronized serial pins
    typedef struct packed {
        logic sck;
        logic mosi;
        logic ssel_n;
    } pins_t;

    // Per-cycle serial events seen in the system clock domain
    typedef struct packed {
        logic sel;       // select active now
        logic sel_rise;  // select became active this cycle
        logic lead;      // clock left its idle level
        logic trail;     // clock returned to its idle level
        logic mosi;      // synchronized data-in
    } ev_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
    import spi_slv_pkg::*;
#(
    parameter bit CPOL = 1'b0
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  pins_t pins_i,
    output ev_t   ev_o,
    output logic  sel_q_o
);

    typedef struct packed {
        logic sck_prev;
        logic sel_prev;
    } st_t;

    st_t  st_d, st_q;
    logic sel_now;
    logic toggled;

    always_comb begin
        sel_now  = ~pins_i.ssel_n;
        toggled  = pins_i.sck ^ st_q.sck_prev;

        ev_o.sel      = sel_now;
        ev_o.sel_rise = sel_now & ~st_q.sel_prev;
        ev_o.lead     = sel_now & toggled & (pins_i.sck != CPOL);
        ev_o.trail    = sel_now & toggled & (pins_i.sck == CPOL);
        ev_o.mosi     = pins_i.mosi;

        st_d          = st_q;
        st_d.sck_prev = pins_i.sck;
        st_d.sel_prev = sel_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sck_prev: CPOL, sel_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q_o = st_q.sel_prev;

endmodule

// File: rtl/spi_slv_xfer.sv
module spi_slv_xfer
    import spi_slv_pkg::*;
#(
    parameter int N         = 8,
    parameter int CNT_W     = 8,
    parameter bit CPHA      = 1'b0,
    parameter bit LSB_FIRST = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  ev_t              ev_i,
    input  logic [N-1:0]     tx_data_i,
    input  logic             tx_load_i,
    output logic             out_bit_o,
    output logic [N-1:0]     rx_data_o,
    output logic             done_o,
    output logic [CNT_W-1:0] rx_count_o
);

    localparam int          CW   = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        logic [N-1:0]     tx_sh;
        logic [N-1:0]     rx_sh;
        logic [N-1:0]     hold;
        logic             hold_v;
        logic [CW-1:0]    cnt;
        logic [N-1:0]     rx_word;
        logic             done;
        logic [CNT_W-1:0] frames;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] tx_adv;
    logic [N-1:0] rx_adv;
    logic [N-1:0] next_word;
    logic         take;

    // Bit order picks the shift direction and the output tap
    if (LSB_FIRST) begin : g_lsb
        assign tx_adv    = {1'b0, st_q.tx_sh[N-1:1]};
        assign rx_adv    = {ev_i.mosi, st_q.rx_sh[N-1:1]};
        assign out_bit_o = st_q.tx_sh[0];
    end else begin : g_msb
        assign tx_adv    = {st_q.tx_sh[N-2:0], 1'b0};
        assign rx_adv    = {st_q.rx_sh[N-2:0], ev_i.mosi};
        assign out_bit_o = st_q.tx_sh[N-1];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        take      = 1'b0;
        next_word = st_q.hold_v ? st_q.hold : '0;

        if (!ev_i.sel) begin
            // idle or aborted frame
            st_d.cnt   = '0;
            st_d.tx_sh = '0;
            st_d.rx_sh = '0;
        end else if (ev_i.sel_rise) begin
            st_d.cnt   = '0;
            st_d.rx_sh = '0;
            if (!CPHA) begin
                st_d.tx_sh = next_word;
                take       = 1'b1;
            end else begin
                st_d.tx_sh = '0;
            end
        end else begin
            if (ev_i.lead) begin
                if (CPHA) begin
                    if (st_q.cnt == '0) begin
                        st_d.tx_sh = next_word;
                        take       = 1'b1;
                    end else begin
                        st_d.tx_sh = tx_adv;
                    end
                end else begin
                    st_d.rx_sh = rx_adv;
                end
            end
            if (ev_i.trail) begin
                if (CPHA) begin
                    st_d.rx_sh = rx_adv;
                end else begin
                    st_d.tx_sh = tx_adv;
                end
                if (st_q.cnt == LAST) begin
                    st_d.cnt     = '0;
                    st_d.done    = 1'b1;
                    st_d.frames  = st_q.frames + 1'b1;
                    st_d.rx_word = CPHA ? rx_adv : st_q.rx_sh;
                    if (!CPHA) begin
                        st_d.tx_sh = next_word;
                        take       = 1'b1;
                    end else begin
                        st_d.tx_sh = '0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        if (take) begin
            st_d.hold_v = 1'b0;
        end
        if (tx_load_i) begin
            st_d.hold   = tx_data_i;
            st_d.hold_v = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data_o  = st_q.rx_word;
    assign done_o     = st_q.done;
    assign rx_count_o = st_q.frames;

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
    import spi_slv_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int CNT_W      = 8,
    parameter bit CLK_IDLE   = 1'b0,
    parameter bit CLK_PHASE  = 1'b0,
    parameter bit LSB_FIRST  = 1'b0
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sclk_i,
    input  logic                  mosi_i,
    input  logic                  ssel_ni,
    input  logic [FRAME_BITS-1:0] tx_data_i,
    input  logic                  tx_load_i,
    output logic                  miso_o,
    output logic                  miso_oe_o,
    output logic [FRAME_BITS-1:0] rx_data_o,
    output logic                  done_o,
    output logic [CNT_W-1:0]      rx_count_o
);

    localparam pins_t PIN_RST = '{sck: CLK_IDLE, mosi: 1'b0, ssel_n: 1'b1};

    pins_t raw_pins;
    pins_t syn_pins;
    ev_t   ev;
    logic  sel_q;
    logic  out_bit;

    assign raw_pins = '{sck: sclk_i, mosi: mosi_i, ssel_n: ssel_ni};

    spi_slv_sync #(
        .WIDTH   ($bits(pins_t)),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_pins),
        .sync_o  (syn_pins)
    );

    spi_slv_edge #(
        .CPOL (CLK_IDLE)
    ) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pins_i  (syn_pins),
        .ev_o    (ev),
        .sel_q_o (sel_q)
    );

    spi_slv_xfer #(
        .N         (FRAME_BITS),
        .CNT_W     (CNT_W),
        .CPHA      (CLK_PHASE),
        .LSB_FIRST (LSB_FIRST)
    ) u_xfer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ev_i       (ev),
        .tx_data_i  (tx_data_i),
        .tx_load_i  (tx_load_i),
        .out_bit_o  (out_bit),
        .rx_data_o  (rx_data_o),
        .done_o     (done_o),
        .rx_count_o (rx_count_o)
    );

    assign miso_oe_o = sel_q;
    assign miso_o    = sel_q & out_bit;

endmodule

// File: rtl/spi_slv_chk.sv
module spi_slv_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ssel_ni,
    input logic             miso_o,
    input logic             miso_oe_o,
    input logic             done_o,
    input logic [CNT_W-1:0] rx_count_o
);

    logic [2:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    // R5: completion is a single-cycle pulse
    p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5: the frame counter moves only with a completion pulse
    p_count_only_on_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((age_q != 3'd0) && (rx_count_o != $past(rx_count_o))) |-> done_o);

    // R5: each completion advances the counter by one
    p_count_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((age_q != 3'd0) && done_o) |-> (rx_count_o == CNT_W'($past(rx_count_o) + 1'b1)));

    // R1: output enable follows the select three clock samples later
    p_oe_tracks_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 3'd4) |-> (miso_oe_o == !$past(ssel_ni, 3)));

    // R10: data-out held low while not enabled
    p_quiet_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !miso_oe_o |-> !miso_o);

    // R8: no completion can be reported outside a selected frame
    p_done_needs_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> miso_oe_o);

endmodule

bind spi_slv_core spi_slv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ssel_ni    (ssel_ni),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .done_o     (done_o),
    .rx_count_o (rx_count_o)
);

// File: tb/spi_slv_core_tb_top.sv
`timescale 1ns/1ps

module spi_slv_ref #(
    parameter int N    = 8,
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0,
    parameter bit LSBF = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         mosi,
    input  logic         ssel_n,
    input  logic [N-1:0] txd,
    input  logic         ld,
    output logic         e_miso,
    output logic         e_oe,
    output logic         e_done,
    output logic [N-1:0] e_rx,
    output logic [7:0]   e_cnt
);
    // delayed views of the pins (two sample stages), plus previous values
    logic d1_sck, d1_mosi, d1_ss, d2_sck, d2_mosi, d2_ss, pv_sck, pv_sel;
    logic [N-1:0] tx_word, rx_acc, hold;
    logic hold_v;
    int out_k, samp, tcount;

    function automatic int pos(input int k);
        return LSBF ? k : (N - 1 - k);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic sel, rise, edg, lead, trail, use_w;
        logic [N-1:0] word;
        if (!rst_n) begin
            d1_sck = CPOL; d2_sck = CPOL; pv_sck = CPOL;
            d1_ss = 1'b1; d2_ss = 1'b1; d1_mosi = 1'b0; d2_mosi = 1'b0;
            pv_sel = 1'b0; tx_word = '0; rx_acc = '0; hold = '0; hold_v = 1'b0;
            out_k = -1; samp = 0; tcount = 0;
            e_oe = 1'b0; e_done = 1'b0; e_rx = '0; e_cnt = '0;
        end else begin
            sel   = !d2_ss;
            rise  = sel && !pv_sel;
            edg   = (d2_sck != pv_sck);
            lead  = sel && edg && (d2_sck != CPOL);
            trail = sel && edg && (d2_sck == CPOL);
            word  = hold_v ? hold : '0;
            use_w = 1'b0;
            e_done = 1'b0;
            if (!sel) begin
                out_k = -1; samp = 0; tcount = 0;
            end else if (rise) begin
                samp = 0; tcount = 0;
                if (!CPHA) begin tx_word = word; out_k = 0; use_w = 1'b1; end
                else out_k = -1;
            end else begin
                if (lead) begin
                    if (CPHA) begin
                        if (out_k < 0) begin tx_word = word; out_k = 0; use_w = 1'b1; end
                        else out_k = out_k + 1;
                    end else begin
                        rx_acc[pos(samp)] = d2_mosi; samp = samp + 1;
                    end
                end
                if (trail) begin
                    if (CPHA) begin rx_acc[pos(samp)] = d2_mosi; samp = samp + 1; end
                    else out_k = out_k + 1;
                    tcount = tcount + 1;
                    if (tcount == N) begin
                        e_done = 1'b1; e_cnt = e_cnt + 8'd1; e_rx = rx_acc;
                        tcount = 0; samp = 0;
                        if (!CPHA) begin tx_word = word; out_k = 0; use_w = 1'b1; end
                        else out_k = -1;
                    end
                end
            end
            if (use_w) hold_v = 1'b0;
            if (ld) begin hold = txd; hold_v = 1'b1; end
            e_oe   = sel;
            pv_sck = d2_sck; pv_sel = sel;
            d2_sck = d1_sck; d2_mosi = d1_mosi; d2_ss = d1_ss;
            d1_sck = sclk;   d1_mosi = mosi;    d1_ss = ssel_n;
        end
    end

    always_comb begin
        if (e_oe && out_k >= 0 && out_k < N) e_miso = tx_word[pos(out_k)];
        else e_miso = 1'b0;
    end
endmodule

module spi_slv_core_tb_top;
    localparam int N = 8;
    localparam int H = 4;   // system clocks per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, ssel_n = 1'b1, mosi_a = 1'b0, mosi_b = 1'b0, tx_load = 1'b0;
    logic [N-1:0] txd_a = '0, txd_b = '0;
    logic sclk_b;

    logic miso_a, oe_a, done_a, miso_b, oe_b, done_b;
    logic [N-1:0] rx_a, rx_b;
    logic [7:0] cnt_a, cnt_b;
    logic em_a, eo_a, ed_a, em_b, eo_b, ed_b;
    logic [N-1:0] er_a, er_b;
    logic [7:0] ec_a, ec_b;

    int tests = 0, fails = 0;
    int dn_a = 0, dn_b = 0;

    always #10 clk = ~clk;
    assign sclk_b = ~sclk;

    spi_slv_core #(.FRAME_BITS(N), .CNT_W(8), .CLK_IDLE(1'b0), .CLK_PHASE(1'b0), .LSB_FIRST(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi_a), .ssel_ni(ssel_n),
        .tx_data_i(txd_a), .tx_load_i(tx_load), .miso_o(miso_a), .miso_oe_o(oe_a),
        .rx_data_o(rx_a), .done_o(done_a), .rx_count_o(cnt_a));

    spi_slv_core #(.FRAME_BITS(N), .CNT_W(8), .CLK_IDLE(1'b1), .CLK_PHASE(1'b1), .LSB_FIRST(1'b1)) dut_b (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk_b), .mosi_i(mosi_b), .ssel_ni(ssel_n),
        .tx_data_i(txd_b), .tx_load_i(tx_load), .miso_o(miso_b), .miso_oe_o(oe_b),
        .rx_data_o(rx_b), .done_o(done_b), .rx_count_o(cnt_b));

    spi_slv_ref #(.N(N), .CPOL(1'b0), .CPHA(1'b0), .LSBF(1'b0)) ref_a (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi_a), .ssel_n(ssel_n), .txd(txd_a),
        .ld(tx_load), .e_miso(em_a), .e_oe(eo_a), .e_done(ed_a), .e_rx(er_a), .e_cnt(ec_a));

    spi_slv_ref #(.N(N), .CPOL(1'b1), .CPHA(1'b1), .LSBF(1'b1)) ref_b (
        .clk(clk), .rst_n(rst_n), .sclk(sclk_b), .mosi(mosi_b), .ssel_n(ssel_n), .txd(txd_b),
        .ld(tx_load), .e_miso(em_b), .e_oe(eo_b), .e_done(ed_b), .e_rx(er_b), .e_cnt(ec_b));

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (done_a) dn_a++;
        if (done_b) dn_b++;
    end

    // every-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 model miso A", miso_a, em_a);
            chk("R1 model oe A", oe_a, eo_a);
            chk("R5 model done A", done_a, ed_a);
            chk("R3 model rx A", rx_a, er_a);
            chk("R5 model count A", cnt_a, ec_a);
            chk("R4 model miso B", miso_b, em_b);
            chk("R1 model oe B", oe_b, eo_b);
            chk("R7 model done B", done_b, ed_b);
            chk("R6 model rx B", rx_b, er_b);
            chk("R5 model count B", cnt_b, ec_b);
        end
    end

    task automatic load_words(input logic [N-1:0] wa, input logic [N-1:0] wb);
        txd_a = wa; txd_b = wb; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic frame(input logic [N-1:0] ma, input logic [N-1:0] mb, input int nbits,
                         input bit reload, input logic [N-1:0] na, input logic [N-1:0] nb,
                         output logic [N-1:0] ca, output logic [N-1:0] cb);
        int d0a, d0b;
        d0a = dn_a; d0b = dn_b;
        ca = '0; cb = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi_a = ma[N-1-i];
            repeat (H) @(negedge clk);
            ca[N-1-i] = miso_a;
            sclk = 1'b1;
            mosi_b = mb[i];
            if (reload && i == 1) begin
                txd_a = na; txd_b = nb; tx_load = 1'b1;
                @(negedge clk);
                tx_load = 1'b0;
                repeat (H-1) @(negedge clk);
            end else begin
                repeat (H) @(negedge clk);
            end
            cb[i] = miso_b;
            if (i == N-1) begin
                chk("R5 no done before last edge A", dn_a - d0a, 0);
                chk("R7 no done before last edge B", dn_b - d0b, 0);
            end
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
    endtask

    task automatic sel_on();
        ssel_n = 1'b0;
        repeat (3) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic sel_off();
        ssel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] ca, cb;
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset miso", {miso_a, miso_b}, 0);
        chk("R12 reset oe", {oe_a, oe_b}, 0);
        chk("R12 reset done", {done_a, done_b}, 0);
        chk("R12 reset rx", {rx_a, rx_b}, 0);
        chk("R12 reset count", {cnt_a, cnt_b}, 0);

        // first frame: A sends 0xA5 MSB-first, B sends 0x3C LSB-first
        load_words(8'hA5, 8'h3C);
        ssel_n = 1'b0;
        @(negedge clk); chk("R1 oe low after 1 edge", oe_a, 0);
        @(negedge clk); chk("R1 oe low after 2 edges", oe_a, 0);
        @(negedge clk); chk("R1 oe high after 3 edges", oe_a, 1);
        chk("R2 first bit on select A", miso_a, 1);
        chk("R4 no bit before first edge B", miso_b, 0);
        repeat (2) @(negedge clk);
        frame(8'h5B, 8'hC6, N, 1'b0, '0, '0, ca, cb);
        chk("R3 tx word A", ca, 8'hA5);
        chk("R6 tx word B LSB first", cb, 8'h3C);
        chk("R3 rx word A", rx_a, 8'h5B);
        chk("R6 rx word B LSB first", rx_b, 8'hC6);
        chk("R5 one done A", dn_a, 1);
        chk("R7 one done B", dn_b, 1);
        chk("R5 count A", cnt_a, 1);
        chk("R5 count B", cnt_b, 1);

        // R11 back-to-back frames with reload mid-frame
        sel_off();
        chk("R10 oe off A", oe_a, 0);
        chk("R10 miso off A", miso_a, 0);
        load_words(8'h81, 8'h7E);
        sel_on();
        frame(8'h12, 8'h34, N, 1'b1, 8'h4D, 8'hB2, ca, cb);
        chk("R11 first word A", ca, 8'h81);
        chk("R11 first word B", cb, 8'h7E);
        frame(8'hF0, 8'h0F, N, 1'b0, '0, '0, ca, cb);
        chk("R11 second word A", ca, 8'h4D);
        chk("R11 second word B", cb, 8'hB2);
        chk("R11 second rx A", rx_a, 8'hF0);
        chk("R11 second rx B", rx_b, 8'h0F);
        chk("R11 count A", cnt_a, 3);
        chk("R11 count B", cnt_b, 3);
        sel_off();

        // R10 clock toggles while deselected
        c0 = dn_a + dn_b;
        for (int k = 0; k < 2 * N; k++) begin
            sclk = ~sclk;
            repeat (H) @(negedge clk);
            chk("R10 no enable while off", {oe_a, oe_b, miso_a, miso_b}, 0);
        end
        chk("R10 no done while off", dn_a + dn_b - c0, 0);
        sclk = 1'b0;
        repeat (4) @(negedge clk);

        // R8 abort after three bits
        load_words(8'hC3, 8'h99);
        sel_on();
        frame(8'hFF, 8'hFF, 3, 1'b0, '0, '0, ca, cb);
        sel_off();
        chk("R8 no done on abort A", dn_a, 3);
        chk("R8 no done on abort B", dn_b, 3);
        chk("R8 count kept A", cnt_a, 3);
        chk("R8 count kept B", cnt_b, 3);

        // R9 frame with nothing loaded; also shows bit counter restarted
        sel_on();
        frame(8'h6A, 8'h95, N, 1'b0, '0, '0, ca, cb);
        chk("R9 zeros A", ca, 0);
        chk("R9 zeros B", cb, 0);
        chk("R8 full rx after abort A", rx_a, 8'h6A);
        chk("R8 full rx after abort B", rx_b, 8'h95);
        chk("R8 count after abort A", cnt_a, 4);
        sel_off();
        repeat (4) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule